// File: doc/BRIEF.md
# Memory Controller Event Counter Bank

This block is a small bank of hardware counters for observing a DDR memory controller. Slot 0 is a free-running clock-cycle counter. Every other slot counts one controller event, picked by an 8-bit select code from a vector of single-cycle event strobes. Each strobe bit is indexed directly by its code, for example 0x04 for read accesses, 0x05 for write accesses, 0x20 and 0x21 for read and write commands, 0x31 for precharge, 0x32 for activate and 0x37 for refresh. Software programs and reads the bank through a simple word-addressed register port.

The cycle counter is the master of the bank. Event slots advance only while it is enabled and has not overflowed. When it wraps, the whole bank freezes and a level interrupt is raised, so software can harvest every count in one consistent snapshot. An event slot that wraps only raises its own sticky flag. A build parameter chooses whether that slot then keeps counting or holds until it is cleared. A preload byte loaded into the cycle counter when it is cleared shortens the time to the next interrupt.

Top module: `mc_evt_bank`

## Requirements
- R1: After reset every control register reads 0x0000_0002 (only the clear bit set), every count reads 0 and `irq` is low.
- R2: The control register of slot n is at word address n (byte offset 4*n) and its count is at word address 8+n (byte offset 0x20+4*n). The control fields are: bit 0 overflow flag, bit 1 clear, bit 2 enable, bits 23:16 preload and bits 31:24 select code. Bits 15:3 read as 0, and reads from unmapped addresses return 0.
- R3: The cycle counter (slot 0) advances by one on every clock while its enable bit is set and its overflow flag is clear.
- R4: The cycle counter is cleared only when a write sets its clear bit while the stored clear bit is 0. Writing 0 and then 1 therefore clears it, and writing 1 over a stored 1 does not. A clear loads the written preload byte into count bits [PRE_LSB+7:PRE_LSB], zeroes all other bits and drops the overflow flag.
- R5: An event slot advances by one in each cycle where the strobe bit indexed by its select code is high, provided its own enable bit is set and the cycle counter is enabled and not overflowed.
- R6: Writing 0 to an event slot's clear bit zeroes its count and overflow flag. From the second cycle after that write, the clear bit reads back as 1 again.
- R7: An event slot whose select code is 0x00, or is not below EVT_W, never advances.
- R8: When the cycle counter wraps from all ones to 0, it sets its overflow flag and every counter in the bank freezes. `irq` then stays high until the cycle counter is cleared as in R4.
- R9: When an event slot wraps, it sets its own overflow flag and `irq` does not change. With STOP_ON_OVF=0 it keeps counting from 0. With STOP_ON_OVF=1 it holds at 0 until it is cleared.
- R10: Writes to count addresses, and to the overflow-flag bit, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 6 | Word address, shared by reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_strobe | input | EVT_W | Event strobes; bit k carries event code k |
| irq | output | 1 | Level interrupt, high while the cycle counter is in overflow |

## Verification
The bench runs the cycle counter from a preload right up to its wrap. It checks that the interrupt rises on exactly the wrapping cycle and that event slots stop there. A design that let events keep running after the master overflow would show grown counts in the frozen snapshot. The bench writes the clear bit in every order. This exposes a cycle counter that clears on a level rather than on a 0-to-1 step: it would lose counts on a plain re-enable, or never clear at all. It also catches an event clear bit that never returns to 1. Two copies that differ only in the overflow mode are driven past an event wrap. A mode mix-up shows up as a count of 2 in the holding copy or 0 in the legacy one, and a stray interrupt shows up as a high `irq`.

// File: rtl/mc_evt_pkg.sv
package mc_evt_pkg;

   localparam int DATA_W     = 32;
   localparam int WADDR_W    = 6;
   localparam int MAX_SLOTS  = 8;
   localparam int VALUE_BASE = 8;

   localparam int F_OVF = 0;
   localparam int F_CLR = 1;
   localparam int F_EN  = 2;
   localparam int F_PRE = 16;
   localparam int F_SEL = 24;

   typedef struct packed {
      logic [7:0] sel;
      logic [7:0] pre;
      logic       en;
      logic       clr;
   } ctrl_wr_t;

endpackage

// File: rtl/mc_evt_pick.sv
module mc_evt_pick #(
   parameter int EVT_W = 128
) (
   input  logic [EVT_W-1:0] strobe,
   input  logic [7:0]       code,
   output logic             hit
);

   localparam int FULL_W = 256;

   logic [FULL_W-1:0] strobe_ext;

   generate
      if (EVT_W == FULL_W) begin : g_full
         assign strobe_ext = strobe;
      end else begin : g_pad
         assign strobe_ext = {{(FULL_W-EVT_W){1'b0}}, strobe};
      end
   endgenerate

   // code 0 belongs to the cycle counter; codes at or above EVT_W hit the zero pad
   assign hit = (code != 8'd0) && strobe_ext[code];

endmodule

// File: rtl/mc_evt_slot.sv
module mc_evt_slot
   import mc_evt_pkg::*;
#(
   parameter bit IS_CYC      = 1'b0,
   parameter int CNT_W       = 32,
   parameter int PRE_LSB     = 16,
   parameter bit STOP_ON_OVF = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  ctrl_wr_t          wfld,
   input  logic              run,
   input  logic              hit,
   output logic [DATA_W-1:0] ctrl_rd,
   output logic [DATA_W-1:0] cnt_rd
);

   logic             en_q, clr_q, ovf_q;
   logic [7:0]       pre_q, sel_q;
   logic [CNT_W-1:0] cnt_q;

   logic             clr_act, clr_nxt, hold, inc;
   logic [CNT_W-1:0] load_val;

   generate
      if (IS_CYC) begin : g_cyc
         // clear fires on a 0-to-1 step of the stored clear bit
         assign clr_act = wr && wfld.clr && !clr_q;
         assign clr_nxt = wr ? wfld.clr : clr_q;
         assign hold    = ovf_q;
         always_comb begin
            load_val = '0;
            load_val[PRE_LSB +: 8] = wfld.pre;
         end
      end else begin : g_evt
         // writing 0 clears; the bit returns to 1 on the following cycle
         assign clr_act  = wr && !wfld.clr;
         assign clr_nxt  = wr ? wfld.clr : 1'b1;
         assign hold     = STOP_ON_OVF ? ovf_q : 1'b0;
         assign load_val = '0;
      end
   endgenerate

   assign inc = en_q && run && hit && !hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         clr_q <= 1'b1;
         ovf_q <= 1'b0;
         pre_q <= '0;
         sel_q <= '0;
         cnt_q <= '0;
      end else begin
         clr_q <= clr_nxt;
         if (wr) begin
            en_q  <= wfld.en;
            pre_q <= wfld.pre;
            sel_q <= wfld.sel;
         end
         if (clr_act) begin
            cnt_q <= load_val;
            ovf_q <= 1'b0;
         end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
            if (&cnt_q) ovf_q <= 1'b1;
         end
      end
   end

   assign ctrl_rd = {sel_q, pre_q, 13'd0, en_q, clr_q, ovf_q};
   assign cnt_rd  = DATA_W'(cnt_q);

endmodule

// File: rtl/mc_evt_bank.sv
module mc_evt_bank
   import mc_evt_pkg::*;
#(
   parameter int NUM_CNT     = 4,
   parameter int CYC_W       = 32,
   parameter int EV_W        = 32,
   parameter int PRE_LSB     = 16,
   parameter int EVT_W       = 128,
   parameter bit STOP_ON_OVF = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [WADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [EVT_W-1:0]   evt_strobe,
   output logic               irq
);

   localparam int IDX_W = $clog2(MAX_SLOTS);

   generate
      if (NUM_CNT < 2 || NUM_CNT > MAX_SLOTS) begin : g_bad_num
         $error("mc_evt_bank: NUM_CNT must be within 2..8");
      end
      if (CYC_W > DATA_W || EV_W > DATA_W || EV_W < 2) begin : g_bad_width
         $error("mc_evt_bank: counter widths must be within 2..32");
      end
      if (PRE_LSB < 0 || PRE_LSB + 8 > CYC_W) begin : g_bad_pre
         $error("mc_evt_bank: preload byte must fit inside the cycle counter");
      end
      if (EVT_W < 2 || EVT_W > 256) begin : g_bad_evt
         $error("mc_evt_bank: EVT_W must be within 2..256");
      end
   endgenerate

   logic [NUM_CNT-1:0][DATA_W-1:0] ctrl_rd;
   logic [NUM_CNT-1:0][DATA_W-1:0] val_rd;
   logic [NUM_CNT-1:0]             wr_hit;
   logic                           cyc_en, bank_run;
   logic                           ctrl_space;
   logic [IDX_W-1:0]               idx;
   ctrl_wr_t                       wfld;

   assign wfld = '{sel: bus_wdata[F_SEL +: 8],
                   pre: bus_wdata[F_PRE +: 8],
                   en:  bus_wdata[F_EN],
                   clr: bus_wdata[F_CLR]};

   assign idx        = bus_addr[IDX_W-1:0];
   assign ctrl_space = (bus_addr[WADDR_W-1:IDX_W] == '0);

   assign cyc_en   = ctrl_rd[0][F_EN];
   assign irq      = ctrl_rd[0][F_OVF];
   assign bank_run = cyc_en && !irq;

   generate
      for (genvar g = 0; g < NUM_CNT; g++) begin : g_slot
         assign wr_hit[g] = bus_wr && ctrl_space && (idx == IDX_W'(g));
         if (g == 0) begin : g_master
            mc_evt_slot #(
               .IS_CYC      (1'b1),
               .CNT_W       (CYC_W),
               .PRE_LSB     (PRE_LSB),
               .STOP_ON_OVF (1'b1)
            ) u_slot (
               .clk     (clk),
               .rst_n   (rst_n),
               .wr      (wr_hit[g]),
               .wfld    (wfld),
               .run     (1'b1),
               .hit     (1'b1),
               .ctrl_rd (ctrl_rd[g]),
               .cnt_rd  (val_rd[g])
            );
         end else begin : g_event
            logic hit;
            mc_evt_pick #(.EVT_W(EVT_W)) u_pick (
               .strobe (evt_strobe),
               .code   (ctrl_rd[g][F_SEL +: 8]),
               .hit    (hit)
            );
            mc_evt_slot #(
               .IS_CYC      (1'b0),
               .CNT_W       (EV_W),
               .PRE_LSB     (PRE_LSB),
               .STOP_ON_OVF (STOP_ON_OVF)
            ) u_slot (
               .clk     (clk),
               .rst_n   (rst_n),
               .wr      (wr_hit[g]),
               .wfld    (wfld),
               .run     (bank_run),
               .hit     (hit),
               .ctrl_rd (ctrl_rd[g]),
               .cnt_rd  (val_rd[g])
            );
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_addr[WADDR_W-1:IDX_W+1] == '0) begin
         for (int i = 0; i < NUM_CNT; i++) begin
            if (idx == IDX_W'(i)) begin
               bus_rdata = bus_addr[IDX_W] ? val_rd[i] : ctrl_rd[i];
            end
         end
      end
   end

endmodule

// File: rtl/mc_evt_bank_chk.sv
module mc_evt_bank_chk #(
   parameter int NUM_CNT = 4,
   parameter int CYC_W   = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_wr,
   input logic                   irq,
   input logic                   cyc_en,
   input logic [NUM_CNT-1:0][31:0] val_rd
);

   logic [CYC_W-1:0] cyc_val;
   assign cyc_val = val_rd[0][CYC_W-1:0];

   // R3: one step per clock while running
   a_r3_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_en && !irq && !bus_wr) |=> (cyc_val == $past(cyc_val) + 1'b1));

   // R5: nothing moves while the master is stopped or overflowed
   a_r5_bank_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      ((!cyc_en || irq) && !bus_wr) |=> $stable(val_rd));

   // R8: a wrap of the running cycle counter raises the interrupt
   a_r8_wrap_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_en && !irq && !bus_wr && (&cyc_val)) |=> irq);

   // R8: the interrupt appears with the counter at zero
   a_r8_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (cyc_val == '0));

   // R8: without a register write the interrupt stays up
   a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !bus_wr) |=> irq);

endmodule

bind mc_evt_bank mc_evt_bank_chk #(
   .NUM_CNT (NUM_CNT),
   .CYC_W   (CYC_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .bus_wr (bus_wr),
   .irq    (irq),
   .cyc_en (cyc_en),
   .val_rd (val_rd)
);

// File: tb/mc_evt_bank_test.sv
module mc_evt_bank_test;

   localparam int CYC_W   = 14;
   localparam int EV_W    = 8;
   localparam int PRE_LSB = 6;
   localparam int EVT_W   = 128;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bus_wr = 1'b0;
   logic [5:0]       bus_addr = '0;
   logic [31:0]      bus_wdata = '0;
   logic [EVT_W-1:0] evt = '0;
   logic [31:0]      rd_a, rd_b;
   logic             irq_a, irq_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   localparam logic [EVT_W-1:0] M4  = EVT_W'(1) << 4;
   localparam logic [EVT_W-1:0] M5  = EVT_W'(1) << 5;
   localparam logic [EVT_W-1:0] ALL = '1;

   always #10 clk = ~clk;

   mc_evt_bank #(.NUM_CNT(4), .CYC_W(CYC_W), .EV_W(EV_W), .PRE_LSB(PRE_LSB),
                 .EVT_W(EVT_W), .STOP_ON_OVF(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rd_a), .evt_strobe(evt), .irq(irq_a));

   mc_evt_bank #(.NUM_CNT(4), .CYC_W(CYC_W), .EV_W(EV_W), .PRE_LSB(PRE_LSB),
                 .EVT_W(EVT_W), .STOP_ON_OVF(1'b1)) uut_stop (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rd_b), .evt_strobe(evt), .irq(irq_b));

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(int word, logic [31:0] d);
      bus_addr  = 6'(word);
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(int word, output logic [31:0] a, output logic [31:0] b);
      bus_addr = 6'(word);
      #1;
      a = rd_a;
      b = rd_b;
   endtask

   task automatic chk_both(string req, string what, int word, logic [31:0] exp);
      logic [31:0] a, b;
      rd(word, a, b);
      chk(req, {what, " (legacy)"}, a, exp);
      chk(req, {what, " (stop)"}, b, exp);
   endtask

   task automatic chk_irq(string req, logic exp);
      chk(req, "irq legacy", 32'(irq_a), 32'(exp));
      chk(req, "irq stop", 32'(irq_b), 32'(exp));
   endtask

   task automatic pulse(logic [EVT_W-1:0] m, int n);
      for (int i = 0; i < n; i++) begin
         evt = m;
         @(negedge clk);
         evt = '0;
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic restart_cyc(logic [7:0] pre);
      wr(0, 32'h0);
      wr(0, {8'h00, pre, 16'h0006});
   endtask

   task automatic t_reset;
      for (int n = 0; n < 4; n++) begin
         chk_both("R1", $sformatf("ctrl%0d reset", n), n, 32'h2);
         chk_both("R1", $sformatf("count%0d reset", n), 8 + n, 32'h0);
      end
      chk_irq("R1", 1'b0);
      chk_both("R2", "unmapped word 20", 20, 32'h0);
      chk_both("R2", "absent slot ctrl word 6", 6, 32'h0);
   endtask

   task automatic t_cycle;
      restart_cyc(8'h00);
      chk_both("R4", "count after clear", 8, 32'd0);
      idle(10);
      chk_both("R3", "count after 10 clocks", 8, 32'd10);
      wr(0, 32'h6);
      chk_both("R4", "1 over 1 does not clear", 8, 32'd11);
      wr(0, 32'h4);
      chk_both("R4", "write 0 alone does not clear", 8, 32'd12);
      wr(0, 32'h6);
      chk_both("R4", "0 then 1 clears", 8, 32'd0);
   endtask

   task automatic t_event;
      logic [31:0] x0, xb;
      restart_cyc(8'h00);
      wr(1, 32'h0400_0004);
      chk_both("R6", "clear bit low right after write", 1, 32'h0400_0004);
      idle(1);
      chk_both("R6", "clear bit back to 1", 1, 32'h0400_0006);
      wr(2, 32'h0500_0004);
      wr(3, 32'h9000_0004);
      pulse(M4, 3);
      pulse(M5, 2);
      pulse(M4 | M5, 1);
      pulse(ALL, 1);
      chk_both("R5", "slot1 code 0x04", 9, 32'd5);
      chk_both("R5", "slot2 code 0x05", 10, 32'd4);
      chk_both("R7", "slot3 code 0x90", 11, 32'd0);
      wr(3, 32'h0000_0004);
      pulse(ALL, 1);
      chk_both("R7", "slot3 code 0x00", 11, 32'd0);
      chk_both("R5", "slot1 all strobes", 9, 32'd6);
      wr(2, 32'h0500_0002);
      pulse(ALL, 1);
      chk_both("R5", "slot2 own enable off", 10, 32'd5);
      chk_both("R5", "slot1 still counting", 9, 32'd7);
      wr(0, 32'h2);
      rd(8, x0, xb);
      pulse(ALL, 2);
      chk_both("R5", "slot1 frozen by master enable", 9, 32'd7);
      chk_both("R3", "cycle frozen while disabled", 8, x0);
      wr(0, 32'h6);
      chk_both("R4", "re-enable without clear step", 8, x0);
      pulse(ALL, 1);
      chk_both("R5", "slot1 resumes", 9, 32'd8);
      chk_both("R3", "cycle resumes", 8, x0 + 32'd1);
      wr(1, 32'h0400_0004);
      chk_both("R6", "slot1 cleared", 9, 32'd0);
   endtask

   task automatic t_ro;
      idle(1);
      pulse(M4, 1);
      chk_both("R5", "slot1 single strobe", 9, 32'd1);
      wr(9, 32'hFFFF_FFFF);
      chk_both("R10", "count write ignored", 9, 32'd1);
      chk_both("R10", "ctrl untouched by count write", 1, 32'h0400_0006);
      wr(1, 32'h0400_0007);
      chk_both("R10", "overflow bit not writable", 1, 32'h0400_0006);
      chk_both("R10", "count after flag write", 9, 32'd1);
   endtask

   task automatic t_evovf;
      logic [31:0] a, b;
      restart_cyc(8'h00);
      wr(1, 32'h0500_0004);
      evt = M5;
      idle(258);
      evt = '0;
      rd(9, a, b);
      chk("R9", "legacy wraps and keeps counting", a, 32'd2);
      chk("R9", "stop mode holds at zero", b, 32'd0);
      chk_both("R9", "event overflow flag", 1, 32'h0500_0007);
      chk_irq("R9", 1'b0);
      wr(1, 32'h0500_0004);
      chk_both("R6", "count after event clear", 9, 32'd0);
      idle(1);
      chk_both("R6", "flag dropped by clear", 1, 32'h0500_0006);
   endtask

   task automatic t_preload;
      wr(1, 32'h0400_0004);
      restart_cyc(8'hF0);
      chk_both("R4", "preload placed in count", 8, 32'h3C00);
      chk_both("R2", "ctrl0 field layout", 0, 32'h00F0_0006);
      pulse(M4, 2);
      chk_both("R5", "slot1 before wrap", 9, 32'd2);
      idle(32'h3FD);
      chk_both("R8", "cycle at all ones", 8, 32'h3FFF);
      chk_irq("R8", 1'b0);
      idle(1);
      chk_both("R8", "cycle wrapped", 8, 32'h0);
      chk_irq("R8", 1'b1);
      chk_both("R8", "master flag", 0, 32'h00F0_0007);
      pulse(M4, 3);
      idle(2);
      chk_both("R8", "cycle frozen", 8, 32'h0);
      chk_both("R8", "slot1 frozen", 9, 32'd2);
      wr(0, 32'h0);
      chk_irq("R8", 1'b1);
      wr(0, 32'h6);
      chk_irq("R8", 1'b0);
      chk_both("R4", "clear after overflow", 8, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cycle();
      t_event();
      t_ro();
      t_evovf();
      t_preload();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R3 watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule